// File: doc/BRIEF.md
# Programmable Three-Port Parallel I/O Unit

This block gives a host bus access to three 8-bit parallel ports, called A, B and C. Port C is handled as two 4-bit halves that can point in different directions. The host works through an 8-bit write bus, an 8-bit read bus, an active-low select, active-low read and write strobes and a 2-bit register address. Writes to the control address do one of two things. They can load a configuration word that sets the direction of each port group. They can also set or clear a single bit of port C.

Each port has an output latch and a drive-enable vector for its external tri-state buffers. When the host reads a port, it gets the latch for an output port and the pin value for an input port. Only simple, unhandshaked I/O is offered. Configuration words that ask for other group modes are stored as written but behave exactly like simple I/O.

Write strobes pass through a two-state acceptor. In `BUS_IDLE`, a selected write strobe commits the write on that clock edge (transition *accept*) and moves to `BUS_HELD`. `BUS_HELD` stays put while the strobe is held (transition *hold*). It returns to `BUS_IDLE` once the select or the write strobe goes high (transition *release*). Reset forces `BUS_IDLE`.

Top module: `pario_unit`

## Requirements
- R1: With `cs_n` low, `addr` 0 selects port A, 1 port B, 2 port C and 3 the control word. A write commits on the rising clock edge at which the acceptor is in `BUS_IDLE` with `cs_n` and `wr_n` low. A port write loads that port's output latch, which appears on its `*_out` pins.
- R2: Synchronous active-high `rst` clears all output latches and loads the control word 0x9B, which makes every group an input. All drive enables then read 0, and reading the control word returns 0x9B.
- R3: A control write with bit 7 = 1 sets the group directions. Bit 4 is port A, bit 1 is port B, bit 3 is the upper half of port C and bit 0 is the lower half, and 1 means input. An output group drives all-ones on its enable bits, and an input group drives zeros.
- R4: Bit 2 and bits 6:5 of a configuration word are kept and read back, but they do not change port behaviour. For example, 0xE4 acts exactly like 0x80.
- R5: Every configuration write (bit 7 = 1) clears the A, B and C output latches to zero.
- R6: A control write with bit 7 = 0 sets port C bit number `wdata[3:1]` to `wdata[0]`. The other port C latch bits, the A and B latches and the stored control word do not change.
- R7: A read of an output group returns its latch, and a read of an input group returns its pins. Each port C half is chosen on its own.
- R8: A read of the control address returns the last configuration word written, or 0x9B after reset.
- R9: With `cs_n` high, writes change nothing, `rd_en` is low and `rd_data` is 0.
- R10: A write strobe held low over several clock edges commits only once, at the first edge. Data changes during the hold are ignored.
- R11: When `rd_en` is low, `rd_data` is 0. `rd_en` is high exactly when `cs_n` and `rd_n` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Unit select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data from host |
| rd_data | output | 8 | Read data to host, 0 when not reading |
| rd_en | output | 1 | Host read bus drive enable |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A drive enables |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B drive enables |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C drive enables, upper and lower halves separate |

## Verification
The bench builds the unit with its package defaults: an 8-bit data path, a 2-bit address and a 3-bit bit selector for port C. This width lets all eight port C bit positions and both halves of port C be reached separately.

The table walk mixes latched and pin readback under several direction words. It includes a split port C, where one half returns the latch and the other returns the pins. It also covers bit set and clear commands and a word with non-default mode bits. Directed tests then cover the drive-enable patterns, a deselected write, a held strobe with changing data, a quiet read bus and a reset in mid-run.

// File: rtl/pario_pkg.sv
`timescale 1ns/1ps
package pario_pkg;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 2;
    localparam int NIB_W     = DATA_W / 2;
    localparam int BIT_SEL_W = $clog2(DATA_W);

    localparam logic [ADDR_W-1:0] SEL_PA   = 2'd0;
    localparam logic [ADDR_W-1:0] SEL_PB   = 2'd1;
    localparam logic [ADDR_W-1:0] SEL_PC   = 2'd2;
    localparam logic [ADDR_W-1:0] SEL_CTRL = 2'd3;

    localparam int CW_MODE_FLAG = 7;
    localparam int CW_A_DIR     = 4;
    localparam int CW_CHI_DIR   = 3;
    localparam int CW_B_DIR     = 1;
    localparam int CW_CLO_DIR   = 0;

    localparam logic [DATA_W-1:0] CW_RESET = 8'h9B;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_HELD = 1'b1
    } bus_state_e;

    typedef struct packed {
        logic a_in;
        logic b_in;
        logic chi_in;
        logic clo_in;
    } port_dir_t;

    function automatic port_dir_t dir_of(input logic [DATA_W-1:0] cw);
        port_dir_t d;
        d.a_in   = cw[CW_A_DIR];
        d.b_in   = cw[CW_B_DIR];
        d.chi_in = cw[CW_CHI_DIR];
        d.clo_in = cw[CW_CLO_DIR];
        return d;
    endfunction
endpackage

// File: rtl/pario_bus_fsm.sv
`timescale 1ns/1ps
module pario_bus_fsm
    import pario_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic wr_n,
    output logic commit
);
    bus_state_e state_q, state_d;
    logic       strobe;

    assign strobe = !cs_n && !wr_n;

    always_ff @(posedge clk) begin
        if (rst) state_q <= BUS_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (strobe)  state_d = BUS_HELD;  // accept
            BUS_HELD: if (!strobe) state_d = BUS_IDLE;  // release, else hold
            default:               state_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        commit = 1'b0;
        unique case (state_q)
            BUS_IDLE: commit = strobe;
            BUS_HELD: commit = 1'b0;
            default:  commit = 1'b0;
        endcase
    end

    assert_single_commit_R10: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit);
endmodule

// File: rtl/pario_regs.sv
`timescale 1ns/1ps
module pario_regs
    import pario_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] pa_q,
    output logic [DATA_W-1:0] pb_q,
    output logic [DATA_W-1:0] pc_q
);
    logic [BIT_SEL_W-1:0] bit_idx;
    assign bit_idx = wdata[BIT_SEL_W:1];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CW_RESET;
            pa_q   <= '0;
            pb_q   <= '0;
            pc_q   <= '0;
        end else if (commit) begin
            unique case (addr)
                SEL_PA: pa_q <= wdata;
                SEL_PB: pb_q <= wdata;
                SEL_PC: pc_q <= wdata;
                SEL_CTRL: begin
                    if (wdata[CW_MODE_FLAG]) begin
                        ctrl_q <= wdata;
                        pa_q   <= '0;
                        pb_q   <= '0;
                        pc_q   <= '0;
                    end else begin
                        pc_q[bit_idx] <= wdata[0];
                    end
                end
                default: ;
            endcase
        end
    end

    assert_mode_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (commit && addr == SEL_CTRL && wdata[CW_MODE_FLAG])
        |=> (pa_q == '0 && pb_q == '0 && pc_q == '0));

    assert_bitcmd_keeps_ctrl_R6: assert property (@(posedge clk) disable iff (rst)
        (commit && addr == SEL_CTRL && !wdata[CW_MODE_FLAG])
        |=> ($stable(ctrl_q) && $stable(pa_q) && $stable(pb_q)));

    assert_no_commit_no_change_R9: assert property (@(posedge clk) disable iff (rst)
        !commit |=> ($stable(ctrl_q) && $stable(pa_q) && $stable(pb_q) && $stable(pc_q)));
endmodule

// File: rtl/pario_rdmux.sv
`timescale 1ns/1ps
module pario_rdmux
    import pario_pkg::*;
(
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] ctrl_q,
    input  logic [DATA_W-1:0] pa_q,
    input  logic [DATA_W-1:0] pb_q,
    input  logic [DATA_W-1:0] pc_q,
    input  logic [DATA_W-1:0] pa_in,
    input  logic [DATA_W-1:0] pb_in,
    input  logic [DATA_W-1:0] pc_in,
    output logic [DATA_W-1:0] rd_data
);
    port_dir_t         dir;
    logic [DATA_W-1:0] pc_view;

    assign dir = dir_of(ctrl_q);

    generate
        for (genvar h = 0; h < 2; h++) begin : g_pc_half
            logic half_in;
            assign half_in = (h == 1) ? dir.chi_in : dir.clo_in;
            assign pc_view[h*NIB_W +: NIB_W] =
                half_in ? pc_in[h*NIB_W +: NIB_W] : pc_q[h*NIB_W +: NIB_W];
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            unique case (addr)
                SEL_PA:   rd_data = dir.a_in ? pa_in : pa_q;
                SEL_PB:   rd_data = dir.b_in ? pb_in : pb_q;
                SEL_PC:   rd_data = pc_view;
                SEL_CTRL: rd_data = ctrl_q;
                default:  rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/pario_unit.sv
`timescale 1ns/1ps
module pario_unit
    import pario_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_en,
    input  logic [DATA_W-1:0] pa_in,
    output logic [DATA_W-1:0] pa_out,
    output logic [DATA_W-1:0] pa_oe,
    input  logic [DATA_W-1:0] pb_in,
    output logic [DATA_W-1:0] pb_out,
    output logic [DATA_W-1:0] pb_oe,
    input  logic [DATA_W-1:0] pc_in,
    output logic [DATA_W-1:0] pc_out,
    output logic [DATA_W-1:0] pc_oe
);
    logic              commit;
    logic [DATA_W-1:0] ctrl_q, pa_q, pb_q, pc_q;
    port_dir_t         dir;

    pario_bus_fsm i_fsm (
        .clk    (clk),
        .rst    (rst),
        .cs_n   (cs_n),
        .wr_n   (wr_n),
        .commit (commit)
    );

    pario_regs i_regs (
        .clk    (clk),
        .rst    (rst),
        .commit (commit),
        .addr   (addr),
        .wdata  (wdata),
        .ctrl_q (ctrl_q),
        .pa_q   (pa_q),
        .pb_q   (pb_q),
        .pc_q   (pc_q)
    );

    assign rd_en = !cs_n && !rd_n;

    pario_rdmux i_rdmux (
        .rd_en   (rd_en),
        .addr    (addr),
        .ctrl_q  (ctrl_q),
        .pa_q    (pa_q),
        .pb_q    (pb_q),
        .pc_q    (pc_q),
        .pa_in   (pa_in),
        .pb_in   (pb_in),
        .pc_in   (pc_in),
        .rd_data (rd_data)
    );

    assign dir    = dir_of(ctrl_q);
    assign pa_out = pa_q;
    assign pb_out = pb_q;
    assign pc_out = pc_q;
    assign pa_oe  = {DATA_W{!dir.a_in}};
    assign pb_oe  = {DATA_W{!dir.b_in}};
    assign pc_oe  = {{NIB_W{!dir.chi_in}}, {NIB_W{!dir.clo_in}}};

    assert_quiet_bus_R11: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rd_data == '0));

    assert_deselect_holds_R9: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out)));
endmodule

// File: tb/test_pario_unit.sv
`timescale 1ns/1ps
module test_pario_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rd_data;
    logic       rd_en;
    logic [7:0] pa_in = 8'hA5, pb_in = 8'h5A, pc_in = 8'hC3;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    pario_unit i_pario_unit (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .rd_data(rd_data), .rd_en(rd_en),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    // {kind(0 write,1 read), addr, data/expected, pa pins, pb pins, pc pins}
    localparam int NVEC = 26;
    localparam logic [39:0] VEC [NVEC] = '{
        40'h0_3_80_A55AC3,  // R3 all outputs
        40'h0_0_12_A55AC3,  // R1
        40'h0_1_34_A55AC3,
        40'h0_2_56_A55AC3,
        40'h1_0_12_A55AC3,  // R7 latch readback
        40'h1_1_34_A55AC3,
        40'h1_2_56_A55AC3,
        40'h0_3_9B_A55AC3,  // all inputs
        40'h1_0_A5_A55AC3,  // R7 pin readback
        40'h1_1_5A_A55AC3,
        40'h1_2_C3_A55AC3,
        40'h1_0_3C_3C5AC3,
        40'h0_3_88_A55AC3,  // C upper in, rest out
        40'h0_2_7E_A55AC3,
        40'h1_2_CE_A55AC3,  // R7 split port C
        40'h1_0_00_A55AC3,  // R5 latch cleared
        40'h1_3_88_A55AC3,  // R8
        40'h0_3_01_A55AC3,  // R6 set bit 0
        40'h1_2_CF_A55AC3,
        40'h0_3_04_A55AC3,  // R6 clear bit 2
        40'h1_2_CB_A55AC3,
        40'h1_3_88_A55AC3,  // R6 ctrl unchanged
        40'h0_3_E4_A55AC3,  // R4 odd mode bits
        40'h1_3_E4_A55AC3,  // R4 stored
        40'h0_0_99_A55AC3,
        40'h1_0_99_A55AC3   // R4 acts as simple output
    };

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic sel_n, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = sel_n; wr_n = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #2 d = rd_data;
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R2 reset state
        bus_read(2'd3, r);  chk("R2 ctrl after reset", r, 8'h9B);
        chk("R2 pa_oe", pa_oe, 8'h00);
        chk("R2 pc_oe", pc_oe, 8'h00);
        chk("R2 pb_out", pb_out, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            pa_in = VEC[i][23:16]; pb_in = VEC[i][15:8]; pc_in = VEC[i][7:0];
            if (VEC[i][36]) begin
                bus_read(VEC[i][33:32], r);
                chk($sformatf("R7/R8 vector %0d", i), r, VEC[i][31:24]);
            end else begin
                bus_write(1'b0, VEC[i][33:32], VEC[i][31:24]);
            end
        end
        pa_in = 8'hA5; pb_in = 8'h5A; pc_in = 8'hC3;

        // R3 enables, R1 latch on pins
        chk("R3 pa_oe all out", pa_oe, 8'hFF);
        chk("R3 pc_oe all out", pc_oe, 8'hFF);
        chk("R1 pa_out", pa_out, 8'h99);
        bus_write(1'b0, 2'd3, 8'h92);
        chk("R3 pa_oe input", pa_oe, 8'h00);
        chk("R3 pb_oe input", pb_oe, 8'h00);
        chk("R3 pc_oe output", pc_oe, 8'hFF);
        chk("R5 pa_out cleared", pa_out, 8'h00);
        bus_write(1'b0, 2'd3, 8'h88);
        chk("R3 pc_oe split", pc_oe, 8'h0F);
        chk("R3 pb_oe output", pb_oe, 8'hFF);

        // R9 deselected write and read
        bus_write(1'b1, 2'd0, 8'h55);
        chk("R9 pa_out after deselected write", pa_out, 8'h00);
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b0; addr = 2'd3;
        #2 chk("R9 rd_data deselected", rd_data, 8'h00);
        chk("R9 rd_en deselected", {7'd0, rd_en}, 8'h00);
        rd_n = 1'b1;

        // R11 quiet bus with select but no read strobe
        @(negedge clk);
        cs_n = 1'b0; addr = 2'd3;
        #2 chk("R11 rd_data idle", rd_data, 8'h00);
        cs_n = 1'b1;

        // R10 held strobe: first value only
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = 2'd0; wdata = 8'h11;
        @(negedge clk);
        wdata = 8'h22;
        @(negedge clk);
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
        chk("R10 pa_out held strobe", pa_out, 8'h11);
        bus_write(1'b0, 2'd0, 8'h33);
        chk("R10 next strobe commits", pa_out, 8'h33);

        // R2 reset in mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R2 pa_out after reset", pa_out, 8'h00);
        chk("R2 pb_oe after reset", pb_oe, 8'h00);
        bus_read(2'd3, r);  chk("R2 R8 ctrl after mid reset", r, 8'h9B);
        bus_read(2'd0, r);  chk("R2 R7 port A reads pins", r, 8'hA5);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule